// File: doc/BRIEF.md
# Hierarchical Priority Event Scheduler

This block makes the dequeue decision for a single consumer. The consumer is wired to a set of connection slots, and each slot is tied to one event queue. Every queue is split into a fixed number of priority sub-queues, and for each slot the block receives a bitmap that says which sub-queues currently hold events. Each slot also has an enable bit and a configured queue priority.

When the consumer is ready and some enabled slot has work, the block makes a decision in two steps. First it picks a queue: the eligible slot with the best queue priority wins. Slots that tie on priority take turns in round-robin order. Then it picks an event level inside that queue: normally the best non-empty level. Occasionally it deliberately takes the next non-empty level below the best one, so that low-priority events are not starved. A pseudo-random generator, compared against a programmable threshold, sets how often this override happens. A threshold near 1% of the generator range gives the usual behaviour.

The block only decides. Event storage, payload transfer, flow locking and reordering belong to the surrounding logic. That logic consumes the registered grant pulse and updates the status bitmaps.

Top module: `prio_evsel`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, grant_valid is low. After reset the round-robin pointer holds slot N_SLOTS-1, so the first tie among all slots grants slot 0. The override generator is seeded with 16'hACE1.
- R2: The block takes a decision at a rising edge only when cons_ready is high and at least one slot is eligible. The decision appears on grant_valid, grant_slot and grant_level right after that edge, and grant_valid is high for exactly that one cycle. With cons_ready low, or with no eligible slot, no grant is issued.
- R3: A slot is eligible only when its slot_en bit is 1 and at least one of its level bits is 1. A slot whose enable is 0 is never granted, whatever its status bits and priority say.
- R4: Among eligible slots, the one with the numerically smallest queue priority wins. Value 0 is the best priority.
- R5: When several eligible slots share the best priority, the winner is the first of them found by scanning upward from the slot after the last granted slot, wrapping from N_SLOTS-1 back to 0.
- R6: With no override, the granted level is the lowest-numbered set bit in the chosen slot's status bitmap. Level 0 is the best level.
- R7: The override generator is a 16-bit register s. On every grant it steps to (s>>1) XOR (s[0] ? 16'hB400 : 0). The override fires for a decision when the value of s before that step is less than starve_thresh. When it fires, the granted level is the second-lowest set bit of the chosen slot's bitmap.
- R8: If the override fires but the chosen slot has only one non-empty level, that level is granted.
- R9: When starve_thresh is 0, the override never fires and the best level is always granted. The generator still steps on every grant.
- R10: The queue priority of slot s is held in slot_prio bits [3s+2:3s]. The status of slot s at level l is lvl_nonempty bit 8s+l. grant_slot and grant_level are plain binary indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 8 | Connection enable, one bit per slot |
| slot_prio | input | 24 | Queue priority per slot, 3 bits each, 0 best |
| lvl_nonempty | input | 64 | Non-empty status, 8 levels per slot |
| starve_thresh | input | 16 | Override threshold; 0 disables the override |
| cons_ready | input | 1 | Consumer can accept an event this cycle |
| grant_valid | output | 1 | One-cycle pulse marking a decision |
| grant_slot | output | 3 | Chosen slot index |
| grant_level | output | 3 | Chosen priority level |

## Verification
The bench checks that the round-robin pointer moves only past the granted slot, so a tie run after reset must start at slot 0. A pointer that moved wrongly or was reset badly would serve the same slot twice or skip one. It sets a disabled slot with the best priority and full status bits next to a worse enabled slot. A design that ignored the enable would grant the disabled queue. With the threshold at its maximum, it expects the second non-empty level, or the only level when just one exists. A design that picked the lowest level, or fell to a level that is empty, would show a wrong grant_level. Long random runs at a middle threshold compare every decision against a model of the generator. A generator that steps at the wrong time, or that compares with the wrong sense, drifts away from the model within a few grants.

// File: rtl/prio_evsel_pkg.sv
package prio_evsel_pkg;
   localparam int DEF_SLOTS   = 8;
   localparam int DEF_LEVELS  = 8;
   localparam int DEF_QPRIO_W = 3;
   localparam int DEF_RND_W   = 16;
   localparam logic [DEF_RND_W-1:0] DEF_TAPS = 16'hB400;
   localparam logic [DEF_RND_W-1:0] DEF_SEED = 16'hACE1;

   typedef enum logic {
      TIE_FIXED = 1'b0,
      TIE_ROUND = 1'b1
   } tie_mode_e;
endpackage

// File: rtl/prio_evsel_lfsr.sv
module prio_evsel_lfsr #(
   parameter int W = prio_evsel_pkg::DEF_RND_W,
   parameter logic [W-1:0] TAPS = prio_evsel_pkg::DEF_TAPS,
   parameter logic [W-1:0] SEED = prio_evsel_pkg::DEF_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] value
);
   logic [W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (step) begin
         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
      end
   end

   assign value = state_q;

   AST_RND_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);  // R7
   AST_RND_STEPS_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> state_q != $past(state_q));  // R7
endmodule

// File: rtl/prio_evsel_slot_arb.sv
module prio_evsel_slot_arb #(
   parameter int N_SLOTS = prio_evsel_pkg::DEF_SLOTS,
   parameter int QP_W    = prio_evsel_pkg::DEF_QPRIO_W,
   parameter prio_evsel_pkg::tie_mode_e TIE = prio_evsel_pkg::TIE_ROUND,
   localparam int SLOT_W = $clog2(N_SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SLOTS-1:0]      slot_en,
   input  logic [N_SLOTS*QP_W-1:0] slot_prio,
   input  logic [N_SLOTS-1:0]      slot_busy,
   input  logic [SLOT_W-1:0]       last_slot,
   output logic                    any_elig,
   output logic [SLOT_W-1:0]       sel_slot
);
   logic [N_SLOTS-1:0] elig;
   logic [N_SLOTS-1:0] cand;
   logic [QP_W-1:0]    best;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_elig
      assign elig[s] = slot_en[s] & slot_busy[s];
   end

   always_comb begin
      best = '1;
      for (int s = 0; s < N_SLOTS; s++) begin
         if (elig[s] && (slot_prio[s*QP_W +: QP_W] < best)) begin
            best = slot_prio[s*QP_W +: QP_W];
         end
      end
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_cand
      assign cand[s] = elig[s] && (slot_prio[s*QP_W +: QP_W] == best);
   end

   assign any_elig = |elig;

   if (TIE == prio_evsel_pkg::TIE_ROUND) begin : g_round
      always_comb begin
         logic found;
         int   idx;
         found    = 1'b0;
         sel_slot = '0;
         for (int k = 1; k <= N_SLOTS; k++) begin
            idx = (int'(last_slot) + k) % N_SLOTS;
            if (!found && cand[idx]) begin
               found    = 1'b1;
               sel_slot = SLOT_W'(idx);
            end
         end
      end
   end else begin : g_fixed
      always_comb begin
         logic found;
         found    = 1'b0;
         sel_slot = '0;
         for (int s = 0; s < N_SLOTS; s++) begin
            if (!found && cand[s]) begin
               found    = 1'b1;
               sel_slot = SLOT_W'(s);
            end
         end
      end
   end

   logic [QP_W-1:0] win_prio;
   assign win_prio = slot_prio[int'(sel_slot)*QP_W +: QP_W];

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_chk
      AST_WINNER_BEST_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
         elig[s] |-> win_prio <= slot_prio[s*QP_W +: QP_W]);  // R4
   end
endmodule

// File: rtl/prio_evsel_lvl_pick.sv
module prio_evsel_lvl_pick #(
   parameter int N_LEVELS = prio_evsel_pkg::DEF_LEVELS,
   localparam int LVL_W = $clog2(N_LEVELS)
) (
   input  logic [N_LEVELS-1:0] bits,
   output logic [LVL_W-1:0]    top_lvl,
   output logic [LVL_W-1:0]    next_lvl,
   output logic                has_next
);
   always_comb begin
      logic seen;
      seen     = 1'b0;
      top_lvl  = '0;
      next_lvl = '0;
      has_next = 1'b0;
      for (int l = 0; l < N_LEVELS; l++) begin
         if (bits[l]) begin
            if (!seen) begin
               seen    = 1'b1;
               top_lvl = LVL_W'(l);
            end else if (!has_next) begin
               has_next = 1'b1;
               next_lvl = LVL_W'(l);
            end
         end
      end
   end
endmodule

// File: rtl/prio_evsel.sv
module prio_evsel #(
   parameter int N_SLOTS  = prio_evsel_pkg::DEF_SLOTS,
   parameter int N_LEVELS = prio_evsel_pkg::DEF_LEVELS,
   parameter int QP_W     = prio_evsel_pkg::DEF_QPRIO_W,
   parameter int RND_W    = prio_evsel_pkg::DEF_RND_W,
   parameter prio_evsel_pkg::tie_mode_e TIE = prio_evsel_pkg::TIE_ROUND,
   localparam int SLOT_W  = $clog2(N_SLOTS),
   localparam int LVL_W   = $clog2(N_LEVELS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SLOTS-1:0]           slot_en,
   input  logic [N_SLOTS*QP_W-1:0]      slot_prio,
   input  logic [N_SLOTS*N_LEVELS-1:0]  lvl_nonempty,
   input  logic [RND_W-1:0]             starve_thresh,
   input  logic                         cons_ready,
   output logic                         grant_valid,
   output logic [SLOT_W-1:0]            grant_slot,
   output logic [LVL_W-1:0]             grant_level
);
   logic [N_SLOTS-1:0]  slot_busy;
   logic [SLOT_W-1:0]   last_q;
   logic [SLOT_W-1:0]   sel_slot;
   logic                any_elig;
   logic [N_LEVELS-1:0] sel_bits;
   logic [LVL_W-1:0]    top_lvl;
   logic [LVL_W-1:0]    next_lvl;
   logic                has_next;
   logic [LVL_W-1:0]    pick_lvl;
   logic [RND_W-1:0]    rnd;
   logic                fire;
   logic                ovr;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_busy
      assign slot_busy[s] = |lvl_nonempty[s*N_LEVELS +: N_LEVELS];
   end

   prio_evsel_slot_arb #(
      .N_SLOTS(N_SLOTS), .QP_W(QP_W), .TIE(TIE)
   ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .slot_en(slot_en), .slot_prio(slot_prio), .slot_busy(slot_busy),
      .last_slot(last_q), .any_elig(any_elig), .sel_slot(sel_slot)
   );

   assign sel_bits = lvl_nonempty[int'(sel_slot)*N_LEVELS +: N_LEVELS];

   prio_evsel_lvl_pick #(.N_LEVELS(N_LEVELS)) u_lvl (
      .bits(sel_bits), .top_lvl(top_lvl), .next_lvl(next_lvl), .has_next(has_next)
   );

   assign fire     = cons_ready & any_elig;
   assign ovr      = rnd < starve_thresh;
   assign pick_lvl = (ovr && has_next) ? next_lvl : top_lvl;

   prio_evsel_lfsr #(.W(RND_W)) u_rnd (
      .clk(clk), .rst_n(rst_n), .step(fire), .value(rnd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_slot  <= '0;
         grant_level <= '0;
         last_q      <= SLOT_W'(N_SLOTS - 1);
      end else begin
         grant_valid <= fire;
         if (fire) begin
            grant_slot  <= sel_slot;
            grant_level <= pick_lvl;
            last_q      <= sel_slot;
         end
      end
   end

   AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $past(cons_ready));  // R2
   AST_GRANT_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> slot_en[sel_slot]);  // R3
   AST_GRANT_LEVEL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> lvl_nonempty[int'(sel_slot)*N_LEVELS + int'(pick_lvl)]);  // R6
   AST_OVERRIDE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && starve_thresh == '0) |-> pick_lvl == top_lvl);  // R9
endmodule

// File: tb/prio_evsel_bench.sv
`timescale 1ns/1ps
module prio_evsel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  slot_en = '0;
   logic [23:0] slot_prio = '0;
   logic [63:0] lvl_nonempty = '0;
   logic [15:0] starve_thresh = '0;
   logic        cons_ready = 1'b0;
   logic        grant_valid;
   logic [2:0]  grant_slot;
   logic [2:0]  grant_level;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   prio_evsel u_prio_evsel (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_prio(slot_prio),
      .lvl_nonempty(lvl_nonempty), .starve_thresh(starve_thresh),
      .cons_ready(cons_ready), .grant_valid(grant_valid),
      .grant_slot(grant_slot), .grant_level(grant_level)
   );

   typedef struct {
      bit    v;
      int    s;
      int    l;
      string tag;
   } exp_t;

   exp_t sb[$];
   int        m_last = 7;
   logic [15:0] m_rnd = 16'hACE1;

   task automatic drive(input logic [7:0] en, input logic [23:0] pr,
                        input logic [63:0] bits, input logic [15:0] thr,
                        input logic rdy, input string tag);
      exp_t e;
      int best;
      bit any;
      bit found;
      int win;
      int first_l;
      int second_l;
      logic [7:0] elig;
      @(negedge clk);
      slot_en = en; slot_prio = pr; lvl_nonempty = bits;
      starve_thresh = thr; cons_ready = rdy;
      best = 8; any = 0; win = 0; found = 0;
      for (int s = 0; s < 8; s++) begin
         elig[s] = en[s] && (bits[s*8 +: 8] != 8'h00);
         if (elig[s]) begin
            any = 1;
            if (int'(pr[s*3 +: 3]) < best) best = int'(pr[s*3 +: 3]);
         end
      end
      e.tag = tag;
      e.v = rdy && any;
      e.s = 0; e.l = 0;
      if (e.v) begin
         for (int k = 1; k <= 8; k++) begin
            int idx;
            idx = (m_last + k) % 8;
            if (!found && elig[idx] && int'(pr[idx*3 +: 3]) == best) begin
               found = 1; win = idx;
            end
         end
         first_l = -1; second_l = -1;
         for (int l = 0; l < 8; l++) begin
            if (bits[win*8 + l]) begin
               if (first_l < 0) first_l = l;
               else if (second_l < 0) second_l = l;
            end
         end
         e.s = win;
         e.l = ((m_rnd < thr) && second_l >= 0) ? second_l : first_l;
         m_last = win;
         m_rnd = {1'b0, m_rnd[15:1]} ^ (m_rnd[0] ? 16'hB400 : 16'h0000);
      end
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      cons_ready = 1'b0;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && !done) begin
            if (sb.size() > 0) begin
               e = sb.pop_front();
               checks++;
               if (grant_valid !== e.v ||
                   (e.v && (int'(grant_slot) != e.s || int'(grant_level) != e.l))) begin
                  errors++;
                  $display("FAIL %s: got valid=%0b slot=%0d level=%0d, expected valid=%0b slot=%0d level=%0d",
                           e.tag, grant_valid, grant_slot, grant_level, e.v, e.s, e.l);
               end
            end else if (grant_valid !== 1'b0) begin
               checks++;
               errors++;
               $display("FAIL R2: got unexpected grant valid=%0b, expected valid=0", grant_valid);
            end
         end
      end
   end

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stimulus
      logic [63:0] l0_all;
      l0_all = '0;
      for (int s = 0; s < 8; s++) l0_all[s*8] = 1'b1;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      checks++;
      if (grant_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: got grant_valid=%0b after reset, expected 0", grant_valid);
      end

      // R5 and R1: full tie, first grant must be slot 0, then rotate
      drive(8'hFF, 24'h0, l0_all, 16'h0, 1'b1, "R1");
      drive(8'hFF, 24'h0, l0_all, 16'h0, 1'b1, "R5");
      drive(8'hFF, 24'h0, l0_all, 16'h0, 1'b1, "R5");
      // R5: sparse tie with wrap
      drive(8'b0010_0101, 24'h0, l0_all, 16'h0, 1'b1, "R5");
      drive(8'b0010_0101, 24'h0, l0_all, 16'h0, 1'b1, "R5");
      drive(8'b0010_0101, 24'h0, l0_all, 16'h0, 1'b1, "R5");
      // R6: single slot, level 5
      drive(8'hFF, 24'h0, 64'h0000_0000_2000_0000, 16'h0, 1'b1, "R6");
      drive(8'hFF, 24'h0, 64'h0000_0000_6800_0000, 16'h0, 1'b1, "R6");
      // R2: consumer not ready
      drive(8'hFF, 24'h0, l0_all, 16'h0, 1'b0, "R2");
      // R3: all disabled yet status full
      drive(8'h00, 24'h0, {64{1'b1}}, 16'h0, 1'b1, "R3");
      // R3: disabled slot 1 with best priority, enabled slot 4 worse
      drive(8'b0001_0000, 24'o77770777 & 24'o77777707, {64{1'b1}}, 16'h0, 1'b1, "R3");
      // R4: slot1 prio4, slot2 prio7, slot6 prio2
      drive(8'hFF, {3'd0,3'd2,3'd0,3'd0,3'd0,3'd7,3'd4,3'd0},
            64'h0001_0000_0000_0100 | 64'h0000_0000_0001_0000, 16'h0, 1'b1, "R4");
      // R4: equal-status slots, best priority wins over lower index
      drive(8'hFF, {3'd3,3'd3,3'd1,3'd3,3'd3,3'd3,3'd3,3'd3}, l0_all, 16'h0, 1'b1, "R4");
      // R7: override with maximum threshold, levels 1,4,6 in slot 2
      drive(8'hFF, 24'h0, 64'h0000_0000_0052_0000, 16'hFFFF, 1'b1, "R7");
      drive(8'hFF, 24'h0, 64'h0000_0000_0052_0000, 16'hFFFF, 1'b1, "R7");
      // R8: override with one level only
      drive(8'hFF, 24'h0, 64'h0000_0000_0000_0800, 16'hFFFF, 1'b1, "R8");
      // R9: threshold zero, best level
      drive(8'hFF, 24'h0, 64'h0000_0000_0000_00C6, 16'h0000, 1'b1, "R9");
      // R10: top slot and top level
      drive(8'hFF, {3'd7,21'h1FFFFF}, 64'h8000_0000_0000_0000, 16'h0, 1'b1, "R10");
      // R7: middle threshold over many decisions
      for (int i = 0; i < 40; i++)
         drive(8'hFF, 24'h0, 64'h0000_0000_0000_8400, 16'h8000, 1'b1, "R7");
      // R4: random traffic
      for (int i = 0; i < 300; i++) begin
         logic [63:0] b;
         logic [15:0] t;
         b = {$urandom, $urandom} & {$urandom, $urandom};
         case ($urandom % 3)
            0: t = 16'd0;
            1: t = 16'd655;
            default: t = 16'h8000;
         endcase
         drive(8'($urandom), 24'($urandom), b, t, 1'($urandom % 4 != 0), "R4");
      end
      idle();
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule